// File: doc/BRIEF.md
# Interrupt Line State Register Bank

This block is the storage core of an interrupt distributor. For every interrupt line it keeps three flags (enabled, pending, active). It also keeps a sensing mode for each line and, for the shared lines, a set of target CPUs. A word-addressed register port gives access to all of this state. Every request carries the number of the CPU that issues it. Lines 0 to 31 are private to each CPU: each CPU has its own enable, pending and active bits for them and sees only its own copy. Lines from 32 upward are shared by all CPUs.

Hardware inputs feed the pending bits. Shared lines take one input each. Lines 16 to 31 take one input per CPU, and lines 0 to 15 have no input, so only software can make them pending. Each line is either level sensitive or edge sensitive. For each CPU the block outputs a map of the lines it would forward to that CPU, and one request wire per CPU that is the OR of that map. Priority selection and acknowledgement are done by logic outside this block.

Top module: `isr_bank`

## Requirements
- R1: After reset, every enable, pending, active, target and control bit is 0. Lines 16 and up are level sensitive, and `irq_out` and `fire_map` are all zero.
- R2: The flags use set and clear word arrays, with line n at bit n%32 of word n/32. Enable-set words start at word address 0x040 and enable-clear at 0x060. Pending-set starts at 0x080 and pending-clear at 0x0A0. Active-set starts at 0x0C0 and active-clear at 0x0E0. Writing a 1 sets or clears that flag and a 0 bit changes nothing. A read of either word of a pair returns the current flags.
- R3: The flags of lines 0 to 31 are held once per CPU. An access by CPU c reads or changes only CPU c's copy. The flags of lines 32 and up are shared.
- R4: Word 0x001 is read-only. Bits [4:0] hold NUM_LINES/32-1, bits [7:5] hold NUM_CPU-1 and all other bits are 0.
- R5: Target words start at word 0x100, one byte per line, with line n in word n/4 at bits (n%4)*8. For a shared line, a write stores the low NUM_CPU bits of its byte and the rest of the byte reads 0. Bit c selects CPU c.
- R6: Target words 0 to 7 cover lines 0 to 31. They ignore writes, and each of their bytes reads back as 1<<c for the requesting CPU c.
- R7: Sense words start at word 0x200, with two bits per line: line n uses bits (n%16)*2+1 (1 means rising edge, 0 means level high) and (n%16)*2 (always reads 0) of word n/16. Lines 0 to 15 always read as edge and ignore writes.
- R8: An edge line becomes pending when its input goes from 0 in one cycle to 1 in the next. Holding the input high does not make it pending again after a clear.
- R9: A level line is set pending in every cycle its input is high, and in those cycles this overrides a clear. After the input drops, the line stays pending until it is cleared.
- R10: Bit c*NUM_LINES+n of `fire_map` is 1 when line n is enabled, pending, not active and targets CPU c. For lines below 32 this uses CPU c's own copy and the target is always c. `irq_out[c]` is the OR of CPU c's bits.
- R11: Bit 0 of control word 0x000 is a global enable. While it is 0, `fire_map` and `irq_out` are all zero.
- R12: `rd_valid` and `rd_data` answer a read in the cycle after the request. Unmapped addresses read 0. A write takes effect for the next cycle.
- R13: Input `ppi_in[c*16+k]` drives line 16+k for CPU c only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | $clog2(NUM_CPU) | Requesting CPU number |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ppi_in | input | NUM_CPU*16 | Per-CPU inputs for lines 16 to 31 |
| spi_in | input | NUM_LINES-32 | Inputs for shared lines 32 and up |
| fire_map | output | NUM_CPU*NUM_LINES | Forwardable lines for each CPU |
| irq_out | output | NUM_CPU | Per-CPU request |

## Verification
The bench builds the block with two CPUs and 64 lines. With this configuration every line can be set and cleared through each flag's register pair, from each CPU in turn, in a few thousand cycles. Two CPUs are enough to show that a private line changed by one CPU stays untouched for the other. Two state words place both a private word and a shared word in the sweep, so the target byte layout, the mask of stored target bits and the sense-bit layout are all checked on real data. Edge, level and per-CPU input behaviour are checked on chosen lines, and forwarding is checked with and without the global enable.

// File: rtl/isr_bank_pkg.sv
package isr_bank_pkg;

    localparam int ADDR_W  = 10;
    localparam int BANK_IN = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 10'h000;
    localparam logic [ADDR_W-1:0] A_TYPE = 10'h001;

    localparam logic [1:0] K_ENA  = 2'd0;
    localparam logic [1:0] K_PEND = 2'd1;
    localparam logic [1:0] K_ACT  = 2'd2;

    typedef enum logic [2:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_BITS, RG_TGT, RG_CFG
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [1:0] kind;
        logic       clr;
        logic [7:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.rg   = RG_NONE;
        d.kind = 2'd0;
        d.clr  = 1'b0;
        d.idx  = 8'd0;
        if (a == A_CTRL) begin
            d.rg = RG_CTRL;
        end else if (a == A_TYPE) begin
            d.rg = RG_TYPE;
        end else if (a[9:8] == 2'b00 && a[7:6] != 2'b00) begin
            d.rg   = RG_BITS;
            d.kind = a[7:6] - 2'd1;
            d.clr  = a[5];
            d.idx  = {3'b000, a[4:0]};
        end else if (a[9:8] == 2'b01) begin
            d.rg  = RG_TGT;
            d.idx = a[7:0];
        end else if (a[9:6] == 4'b1000) begin
            d.rg  = RG_CFG;
            d.idx = {2'b00, a[5:0]};
        end
        return d;
    endfunction

    function automatic logic [31:0] sel_mask(input logic hit, input dec_t d,
                                             input logic [1:0] k, input logic c,
                                             input logic [31:0] wd);
        return (hit && d.kind == k && d.clr == c) ? wd : 32'd0;
    endfunction

endpackage

// File: rtl/isr_state_word.sv
module isr_state_word (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ena_set,
    input  logic [31:0] ena_clr,
    input  logic [31:0] pend_set,
    input  logic [31:0] pend_clr,
    input  logic [31:0] act_set,
    input  logic [31:0] act_clr,
    input  logic [31:0] hw_set,
    output logic [31:0] ena,
    output logic [31:0] pend,
    output logic [31:0] act
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ena  <= '0;
            pend <= '0;
            act  <= '0;
        end else begin
            ena  <= ena_set | (ena & ~ena_clr);
            pend <= pend_set | hw_set | (pend & ~pend_clr);
            act  <= act_set | (act & ~act_clr);
        end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (|ena_set) |=> ((ena & $past(ena_set)) == $past(ena_set)))
        else $error("enable set bits not applied");

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        ((|act_clr) && act_set == 32'd0) |=> ((act & $past(act_clr)) == 32'd0))
        else $error("active clear bits not applied");

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (pend_set == 32'd0 && pend_clr == 32'd0 && hw_set == 32'd0) |=> $stable(pend))
        else $error("pending changed without cause");

endmodule

// File: rtl/isr_route.sv
module isr_route #(
    parameter int NUM_CPU   = 2,
    parameter int NUM_LINES = 64
) (
    input  logic                                 glob_en,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0]    ena,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0]    pend,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0]    act,
    input  logic [NUM_CPU-1:0][NUM_LINES-1:0]    tgt,
    output logic [NUM_CPU-1:0][NUM_LINES-1:0]    fire,
    output logic [NUM_CPU-1:0]                   irq
);

    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            fire[c] = ena[c] & pend[c] & ~act[c] & tgt[c] & {NUM_LINES{glob_en}};
            irq[c]  = |fire[c];
        end
    end

endmodule

// File: rtl/isr_bank.sv
module isr_bank
    import isr_bank_pkg::*;
#(
    parameter int NUM_CPU   = 2,
    parameter int NUM_LINES = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [$clog2(NUM_CPU)-1:0]    req_cpu,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    output logic                          rd_valid,
    output logic [31:0]                   rd_data,
    input  logic [NUM_CPU*BANK_IN-1:0]    ppi_in,
    input  logic [NUM_LINES-33:0]         spi_in,
    output logic [NUM_CPU*NUM_LINES-1:0]  fire_map,
    output logic [NUM_CPU-1:0]            irq_out
);

    localparam int CPU_W = $clog2(NUM_CPU);
    localparam int LW    = $clog2(NUM_LINES);
    localparam int NW    = NUM_LINES / 32;
    localparam int NSH   = NUM_LINES - 32;
    localparam logic [31:0] TYPE_WORD = {24'd0, 3'(NUM_CPU - 1), 5'(NW - 1)};

    dec_t dec;
    logic wr;
    assign dec = decode_addr(req_addr);
    assign wr  = req_valid && req_write;

    logic glob_en;
    wire [NUM_CPU-1:0][NUM_LINES-1:0] v_ena, v_pend, v_act, v_tgt;
    wire [NUM_LINES-1:0]              edge_v;
    wire [NUM_LINES-1:0][7:0]         tgt_rd;
    logic [7:0]                       own_mask;
    logic [NUM_CPU*BANK_IN-1:0]       ppi_prev;
    logic [NSH-1:0]                   spi_prev;
    logic [NUM_CPU-1:0][NUM_LINES-1:0] fire;

    assign own_mask = 8'(1) << req_cpu;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en  <= 1'b0;
            ppi_prev <= '0;
            spi_prev <= '0;
        end else begin
            if (wr && dec.rg == RG_CTRL) glob_en <= req_wdata[0];
            ppi_prev <= ppi_in;
            spi_prev <= spi_in;
        end
    end

    // Sense mode and target storage, one slice per line
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        if (n < 16) begin : g_fixed_cfg
            assign edge_v[n] = 1'b1;
        end else begin : g_rw_cfg
            logic edge_q;
            always_ff @(posedge clk) begin
                if (rst) edge_q <= 1'b0;
                else if (wr && dec.rg == RG_CFG && dec.idx == 8'(n / 16))
                    edge_q <= req_wdata[(n % 16) * 2 + 1];
            end
            assign edge_v[n] = edge_q;
        end

        if (n < 32) begin : g_own_tgt
            assign tgt_rd[n] = own_mask;
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
                assign v_tgt[c][n] = 1'b1;
            end
        end else begin : g_sh_tgt
            logic [NUM_CPU-1:0] tq;
            always_ff @(posedge clk) begin
                if (rst) tq <= '0;
                else if (wr && dec.rg == RG_TGT && dec.idx == 8'(n / 4))
                    tq <= req_wdata[(n % 4) * 8 +: NUM_CPU];
            end
            assign tgt_rd[n] = 8'(tq);
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_c
                assign v_tgt[c][n] = tq[c];
            end

            assert_level_R9: assert property (@(posedge clk) disable iff (rst)
                (!edge_v[n] && spi_in[n-32]) |=> v_pend[0][n])
                else $error("level line not pending while input high");

            assert_edge_R8: assert property (@(posedge clk) disable iff (rst)
                (edge_v[n] && spi_in[n-32] && !spi_prev[n-32]) |=> v_pend[0][n])
                else $error("rising edge not captured");
        end
    end

    // Private state word per CPU for lines 0..31
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        wire        hit;
        wire [31:0] hw;
        logic [31:0] e, p, a;
        assign hit = wr && dec.rg == RG_BITS && dec.idx == 8'd0 && req_cpu == CPU_W'(c);
        for (genvar k = 0; k < 32; k++) begin : g_hw
            if (k < 16) begin : g_none
                assign hw[k] = 1'b0;
            end else begin : g_in
                assign hw[k] = edge_v[k]
                    ? (ppi_in[c*BANK_IN + k - 16] & ~ppi_prev[c*BANK_IN + k - 16])
                    : ppi_in[c*BANK_IN + k - 16];
            end
        end
        isr_state_word u_word (
            .clk(clk), .rst(rst),
            .ena_set (sel_mask(hit, dec, K_ENA,  1'b0, req_wdata)),
            .ena_clr (sel_mask(hit, dec, K_ENA,  1'b1, req_wdata)),
            .pend_set(sel_mask(hit, dec, K_PEND, 1'b0, req_wdata)),
            .pend_clr(sel_mask(hit, dec, K_PEND, 1'b1, req_wdata)),
            .act_set (sel_mask(hit, dec, K_ACT,  1'b0, req_wdata)),
            .act_clr (sel_mask(hit, dec, K_ACT,  1'b1, req_wdata)),
            .hw_set(hw), .ena(e), .pend(p), .act(a)
        );
        assign v_ena[c][31:0]  = e;
        assign v_pend[c][31:0] = p;
        assign v_act[c][31:0]  = a;

        assert_bank_isolate_R3: assert property (@(posedge clk) disable iff (rst)
            (wr && dec.rg == RG_BITS && dec.idx == 8'd0 && req_cpu != CPU_W'(c))
            |=> ($stable(v_ena[c][31:0]) && $stable(v_act[c][31:0])))
            else $error("private word changed by another CPU");
    end

    // Shared state words for lines 32 and up
    for (genvar w = 1; w < NW; w++) begin : g_shared
        wire        hit;
        wire [31:0] hw;
        logic [31:0] e, p, a;
        assign hit = wr && dec.rg == RG_BITS && dec.idx == 8'(w);
        for (genvar k = 0; k < 32; k++) begin : g_hw
            assign hw[k] = edge_v[w*32 + k]
                ? (spi_in[w*32 + k - 32] & ~spi_prev[w*32 + k - 32])
                : spi_in[w*32 + k - 32];
        end
        isr_state_word u_word (
            .clk(clk), .rst(rst),
            .ena_set (sel_mask(hit, dec, K_ENA,  1'b0, req_wdata)),
            .ena_clr (sel_mask(hit, dec, K_ENA,  1'b1, req_wdata)),
            .pend_set(sel_mask(hit, dec, K_PEND, 1'b0, req_wdata)),
            .pend_clr(sel_mask(hit, dec, K_PEND, 1'b1, req_wdata)),
            .act_set (sel_mask(hit, dec, K_ACT,  1'b0, req_wdata)),
            .act_clr (sel_mask(hit, dec, K_ACT,  1'b1, req_wdata)),
            .hw_set(hw), .ena(e), .pend(p), .act(a)
        );
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_view
            assign v_ena[c][w*32 +: 32]  = e;
            assign v_pend[c][w*32 +: 32] = p;
            assign v_act[c][w*32 +: 32]  = a;
        end
    end

    isr_route #(.NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES)) u_route (
        .glob_en(glob_en), .ena(v_ena), .pend(v_pend), .act(v_act), .tgt(v_tgt),
        .fire(fire), .irq(irq_out)
    );
    assign fire_map = fire;

    assert_gate_R11: assert property (@(posedge clk) disable iff (rst)
        !glob_en |-> (fire_map == '0 && irq_out == '0))
        else $error("forwarding while globally disabled");

    // Read path, registered
    logic [31:0]   rd_next;
    logic [LW-1:0] wbase;
    always_comb begin
        rd_next = '0;
        wbase   = LW'(int'(dec.idx) * 32);
        case (dec.rg)
            RG_CTRL: rd_next = {31'd0, glob_en};
            RG_TYPE: rd_next = TYPE_WORD;
            RG_BITS: if (int'(dec.idx) < NW) begin
                case (dec.kind)
                    K_ENA:   rd_next = v_ena[req_cpu][wbase +: 32];
                    K_PEND:  rd_next = v_pend[req_cpu][wbase +: 32];
                    K_ACT:   rd_next = v_act[req_cpu][wbase +: 32];
                    default: rd_next = '0;
                endcase
            end
            RG_TGT: if (int'(dec.idx) < NUM_LINES / 4) begin
                for (int b = 0; b < 4; b++)
                    rd_next[b*8 +: 8] = tgt_rd[LW'(int'(dec.idx) * 4 + b)];
            end
            RG_CFG: if (int'(dec.idx) < NUM_LINES / 16) begin
                for (int k = 0; k < 16; k++)
                    rd_next[k*2 + 1] = edge_v[LW'(int'(dec.idx) * 16 + k)];
            end
            default: rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_next : 32'd0;
        end
    end

endmodule

// File: tb/sim_isr_bank.sv
module sim_isr_bank;

    localparam int NC = 2;
    localparam int NL = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic             req_cpu   = 1'b0;
    logic [9:0]       req_addr  = '0;
    logic [31:0]      req_wdata = '0;
    logic             rd_valid;
    logic [31:0]      rd_data;
    logic [NC*16-1:0] ppi_in = '0;
    logic [NL-33:0]   spi_in = '0;
    logic [NC*NL-1:0] fire_map;
    logic [NC-1:0]    irq_out;

    isr_bank #(.NUM_CPU(NC), .NUM_LINES(NL)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ppi_in(ppi_in), .spi_in(spi_in),
        .fire_map(fire_map), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] got;
    logic        got_v;
    logic [NC-1:0][NL-1:0] m_st [3];

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int c, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_cpu = 1'(c);
        req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int c, input logic [9:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = 1'(c); req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        got = rd_data; got_v = rd_valid;
    endtask

    function automatic logic [9:0] bit_addr(input int k, input int clr, input int w);
        return 10'(64 + k * 64 + clr * 32 + w);
    endfunction

    task automatic mset(input int k, input int c, input int n, input logic v);
        if (n < 32) m_st[k][c][n] = v;
        else for (int cc = 0; cc < NC; cc++) m_st[k][cc][n] = v;
    endtask

    task automatic verify_word(input int k, input int w);
        for (int cc = 0; cc < NC; cc++)
            for (int clr = 0; clr < 2; clr++) begin
                rd(cc, bit_addr(k, clr, w));
                chk(w == 0 ? "R3 private flags" : "R2 shared flags", 128'(got),
                    128'(m_st[k][cc][w*32 +: 32]));
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) m_st[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq_out", 128'(irq_out), 128'd0);
        chk("R1 fire_map", 128'(fire_map), 128'd0);
        rd(0, 10'h000); chk("R1 control", 128'(got), 128'd0);
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < 2; w++) begin
                rd(w, bit_addr(k, 0, w)); chk("R1 flags", 128'(got), 128'd0);
            end
        rd(0, 10'h201); chk("R1 sense", 128'(got), 128'd0);
        rd(1, 10'h108); chk("R1 target", 128'(got), 128'd0);

        // R4 type word, R12 read timing and unmapped
        rd(0, 10'h001); chk("R4 type", 128'(got), 128'h21);
        chk("R12 rd_valid", 128'(got_v), 128'd1);
        rd(1, 10'h3F0); chk("R12 unmapped", 128'(got), 128'd0);
        rd(1, 10'h020); chk("R12 unmapped low", 128'(got), 128'd0);

        // R2 R3 sweep of every line, flag and CPU
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < NL; n++)
                for (int c = 0; c < NC; c++) begin
                    wr(c, bit_addr(k, 0, n / 32), 32'(1) << (n % 32));
                    mset(k, c, n, 1'b1);
                    verify_word(k, n / 32);
                    wr(c, bit_addr(k, 1, n / 32), 32'(1) << (n % 32));
                    mset(k, c, n, 1'b0);
                    verify_word(k, n / 32);
                end

        // R2 zero bits have no effect
        wr(0, bit_addr(0, 0, 1), 32'h0000_0002);
        wr(1, bit_addr(0, 0, 1), 32'h0);
        wr(1, bit_addr(0, 1, 1), 32'h0);
        rd(0, bit_addr(0, 0, 1)); chk("R2 zero write", 128'(got), 128'h2);
        wr(0, bit_addr(0, 1, 1), 32'h0000_0002);

        // R6 private target bytes
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < 8; w++) begin
                wr(c, 10'(256 + w), 32'hFFFF_FFFF);
                rd(c, 10'(256 + w));
                chk("R6 private target", 128'(got), 128'({4{8'(1 << c)}}));
            end
        // R5 shared target bytes
        for (int w = 8; w < NL / 4; w++) begin
            logic [31:0] d;
            d = (32'(w) * 32'h0101_0101) ^ 32'h5A3C_96E1;
            wr(w % 2, 10'(256 + w), d);
            for (int c = 0; c < NC; c++) begin
                rd(c, 10'(256 + w));
                chk("R5 shared target", 128'(got), 128'(d & 32'h0303_0303));
            end
        end

        // R7 sense words
        wr(0, 10'h200, 32'h0);
        rd(1, 10'h200); chk("R7 fixed sense", 128'(got), 128'hAAAA_AAAA);
        for (int w = 1; w < 4; w++) begin
            wr(1, 10'(512 + w), 32'hFFFF_FFFF);
            rd(0, 10'(512 + w)); chk("R7 sense write", 128'(got), 128'hAAAA_AAAA);
            wr(0, 10'(512 + w), 32'h0);
            rd(1, 10'(512 + w)); chk("R7 sense clear", 128'(got), 128'd0);
        end

        // R8 edge line 40 (input bit 8)
        wr(0, 10'h202, 32'h0002_0000);
        @(negedge clk); spi_in[8] = 1'b1;
        rd(0, bit_addr(1, 0, 1)); chk("R8 edge pend", 128'(got), 128'h100);
        wr(0, bit_addr(1, 1, 1), 32'h100);
        rd(1, bit_addr(1, 0, 1)); chk("R8 held high", 128'(got), 128'd0);
        @(negedge clk); spi_in[8] = 1'b0;
        @(negedge clk); spi_in[8] = 1'b1;
        rd(1, bit_addr(1, 0, 1)); chk("R8 second edge", 128'(got), 128'h100);
        wr(0, bit_addr(1, 1, 1), 32'h100);
        @(negedge clk); spi_in[8] = 1'b0;

        // R9 level line 41 (input bit 9)
        @(negedge clk); spi_in[9] = 1'b1;
        rd(0, bit_addr(1, 0, 1)); chk("R9 level pend", 128'(got), 128'h200);
        wr(0, bit_addr(1, 1, 1), 32'h200);
        rd(0, bit_addr(1, 0, 1)); chk("R9 clear overridden", 128'(got), 128'h200);
        @(negedge clk); spi_in[9] = 1'b0;
        rd(0, bit_addr(1, 0, 1)); chk("R9 latched", 128'(got), 128'h200);
        wr(1, bit_addr(1, 1, 1), 32'h200);
        rd(0, bit_addr(1, 0, 1)); chk("R9 cleared", 128'(got), 128'd0);

        // R13 per-CPU input, line 20 of CPU 1
        @(negedge clk); ppi_in[20] = 1'b1;
        rd(1, bit_addr(1, 0, 0)); chk("R13 own copy", 128'(got), 128'h0010_0000);
        rd(0, bit_addr(1, 0, 0)); chk("R13 other copy", 128'(got), 128'd0);
        @(negedge clk); ppi_in[20] = 1'b0;
        wr(1, bit_addr(1, 1, 0), 32'h0010_0000);
        rd(1, bit_addr(1, 0, 0)); chk("R13 cleared", 128'(got), 128'd0);

        // R10 R11 forwarding
        wr(0, 10'(256 + 10), 32'h0000_0002);
        wr(0, bit_addr(0, 0, 1), 32'h100);
        wr(1, bit_addr(1, 0, 1), 32'h100);
        chk("R11 disabled irq", 128'(irq_out), 128'd0);
        chk("R11 disabled map", 128'(fire_map), 128'd0);
        wr(0, 10'h000, 32'h1);
        chk("R10 irq cpu1", 128'(irq_out), 128'b10);
        chk("R10 map cpu1", 128'(fire_map), 128'd1 << (NL + 40));
        wr(1, bit_addr(2, 0, 1), 32'h100);
        chk("R10 active blocks", 128'(irq_out), 128'd0);
        wr(1, bit_addr(2, 1, 1), 32'h100);
        wr(0, bit_addr(0, 0, 0), 32'h20);
        wr(0, bit_addr(1, 0, 0), 32'h20);
        chk("R10 private line", 128'(irq_out), 128'b11);
        chk("R10 both maps", 128'(fire_map), (128'd1 << (NL + 40)) | 128'h20);
        wr(1, bit_addr(0, 1, 0), 32'h20);
        chk("R3 other CPU clear ignored", 128'(irq_out), 128'b11);
        wr(1, 10'h000, 32'h0);
        chk("R11 disabled again", 128'(irq_out), 128'd0);
        rd(1, 10'h000); chk("R11 control read", 128'(got), 128'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule